// File: doc/BRIEF.md
# Set-Associative Cache Controller with Aging Replacement

The block sits between a processor that issues word loads and stores and a memory that moves whole lines. Each line of every set keeps an address tag, a valid flag, a modified flag and a small age counter. A lookup compares the request tag with every way of the selected set in parallel. A hit completes in the cycle it is presented. A miss starts a short sequence. If the chosen victim is both valid and modified, it is first written back. The missing line is then fetched. The original request then completes as a hit.

Replacement does not keep a full recency order. When a line is touched, its age counter is loaded with its maximum value. A free-running timer ticks every `TICK_CYCLES` cycles and lowers every non-zero counter by one. The victim is chosen in this order: an empty way; failing that, a way whose age has reached zero; failing that, way 0. Stores use byte enables. A store that misses first allocates the line and then writes it.

The controller has three named states. `ST_IDLE` serves hits and decides on a miss. `ST_WRITEBACK` holds a line write to memory. `ST_REFILL` holds a line read. The transitions are:
- `ST_IDLE` goes to `ST_WRITEBACK` on a miss whose victim is valid and modified.
- `ST_IDLE` goes to `ST_REFILL` on any other miss.
- `ST_WRITEBACK` goes to `ST_REFILL` when memory accepts the write.
- `ST_REFILL` goes back to `ST_IDLE` when memory returns the line.

Top module: `setassoc_cache`

## Requirements
- R1: A byte address is split, from bit 0 upward, into a 2-bit byte field, a word-in-line field of log2(LINE_WORDS) bits, a set field of log2(SETS) bits, and a tag made of all remaining upper bits. With the defaults, the word is bit 2, the set is bits 4:3 and the tag is bits 31:5. Word w of a line occupies line bits [32w+31:32w]. Every memory address is line aligned.
- R2: A request whose tag matches a valid way of its set is a hit. On a hit, cpu_ready is high in the same cycle and no memory request is made.
- R3: Reset marks every line invalid, so the first access to any address after reset is a miss.
- R4: A load returns the most recent value stored to that word. Each store writes only the bytes whose cpu_be bit is 1; cpu_be bit b covers data bits [8b+7:8b].
- R5: A store hit marks its line modified. Evicting a modified line issues a line write of the old contents to the old line address, and that write comes before the refill read.
- R6: Evicting a line that is invalid or unmodified causes exactly one line read and no write.
- R7: If any way in the set is invalid, the lowest-numbered invalid way is filled.
- R8: If all ways are valid, the lowest-numbered way whose age is zero is replaced.
- R9: If all ways are valid and none has age zero, way 0 is replaced.
- R10: An access or a fill loads the line's age with 2^AGE_W-1. Every TICK_CYCLES cycles the timer lowers each non-zero age by one, and an age of zero stays at zero.
- R11: While a miss is in progress, cpu_ready stays low until the refill has completed. A store miss allocates the line and then applies the store.
- R12: Once mem_req is raised, it stays high with the same mem_addr and mem_we until mem_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W | Line-aligned byte address |
| mem_wdata | output | 32*LINE_WORDS | Line being written back |
| mem_rdata | input | 32*LINE_WORDS | Line returned by memory |
| mem_ready | input | 1 | Memory completes the transfer this cycle |

## Verification
The directed cases target the replacement order.

- After a long idle period, a set is touched on one way and then misses. A design that ignored the invalid-way preference, or picked by age alone, would evict the wrong resident. The wrong choice shows up as an unexpected miss on the line that should have stayed.
- When two fresh lines are touched and a third tag arrives, way 0 must fall. A design with a different fallback would keep the wrong line.
- Evicting a modified line must write the old data to the old address before reading. A design that forgot the modified flag, wrote the new address, or reversed the order would lose data, and the backing store would then disagree with the expected model.
- A store miss checks write-allocate, and partial byte enables check the merge.
- A seeded random mix of loads and stores over a few conflicting tags checks every load against a bench-side image of memory.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_REFILL    = 2'd2
    } cache_state_t;

    localparam int WORD_BITS = 32;
    localparam int BYTE_BITS = 2;

endpackage

// File: rtl/cache_age_tick.sv
module cache_age_tick #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == CNT_W'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 27
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           lookup_tag,
    output logic                       hit,
    output logic [$clog2(WAYS)-1:0]    hit_way
);
    logic [WAYS-1:0] match_vec;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match_vec[g] = way_valid[g] && (way_tag[g] == lookup_tag);
    end

    assign hit = |match_vec;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) hit_way = ($clog2(WAYS))'(w);
        end
    end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
    parameter int WAYS  = 2,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][AGE_W-1:0] way_age,
    output logic [$clog2(WAYS)-1:0]    victim
);
    localparam int WAY_W = $clog2(WAYS);

    logic             have_empty, have_old;
    logic [WAY_W-1:0] empty_way,  old_way;

    always_comb begin
        have_empty = 1'b0;
        have_old   = 1'b0;
        empty_way  = '0;
        old_way    = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                have_empty = 1'b1;
                empty_way  = WAY_W'(w);
            end
            if (way_age[w] == '0) begin
                have_old = 1'b1;
                old_way  = WAY_W'(w);
            end
        end
        if (have_empty)    victim = empty_way;
        else if (have_old) victim = old_way;
        else               victim = '0;
    end
endmodule

// File: rtl/setassoc_cache.sv
module setassoc_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SETS        = 4,
    parameter int WAYS        = 2,
    parameter int LINE_WORDS  = 2,
    parameter int AGE_W       = 2,
    parameter int TICK_CYCLES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [3:0]                   cpu_be,
    input  logic [31:0]                  cpu_wdata,
    output logic                         cpu_ready,
    output logic [31:0]                  cpu_rdata,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [32*LINE_WORDS-1:0]     mem_wdata,
    input  logic [32*LINE_WORDS-1:0]     mem_rdata,
    input  logic                         mem_ready
);
    localparam int WOFF_W  = $clog2(LINE_WORDS);
    localparam int INDEX_W = $clog2(SETS);
    localparam int LOW_W   = BYTE_BITS + WOFF_W;
    localparam int TAG_W   = ADDR_W - INDEX_W - LOW_W;
    localparam int LINE_W  = WORD_BITS * LINE_WORDS;
    localparam int WAY_W   = $clog2(WAYS);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    // Address fields (R1)
    logic [INDEX_W-1:0] set_idx;
    logic [WOFF_W-1:0]  word_sel;
    logic [TAG_W-1:0]   req_tag;

    assign word_sel = cpu_addr[BYTE_BITS +: WOFF_W];
    assign set_idx  = cpu_addr[LOW_W +: INDEX_W];
    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

    // Line storage
    logic [TAG_W-1:0]             tag_q   [SETS][WAYS];
    logic [LINE_W-1:0]            data_q  [SETS][WAYS];
    logic [WAYS-1:0]              valid_q [SETS];
    logic [WAYS-1:0]              dirty_q [SETS];
    logic [WAYS-1:0][AGE_W-1:0]   age_q   [SETS];

    logic [WAYS-1:0][TAG_W-1:0]   set_tags;
    logic                         hit;
    logic [WAY_W-1:0]             hit_way, victim_way, victim_q;
    logic                         tick;

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[set_idx][w];
    end

    cache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_tag    (set_tags),
        .way_valid  (valid_q[set_idx]),
        .lookup_tag (req_tag),
        .hit        (hit),
        .hit_way    (hit_way)
    );

    cache_victim_sel #(.WAYS(WAYS), .AGE_W(AGE_W)) u_victim (
        .way_valid (valid_q[set_idx]),
        .way_age   (age_q[set_idx]),
        .victim    (victim_way)
    );

    cache_age_tick #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // Hit data path
    logic [LINE_W-1:0] hit_line, hit_line_new;

    assign hit_line  = data_q[set_idx][hit_way];
    assign cpu_rdata = hit_line[word_sel*WORD_BITS +: WORD_BITS];

    always_comb begin
        hit_line_new = hit_line;
        for (int b = 0; b < 4; b++) begin
            if (cpu_be[b]) hit_line_new[word_sel*WORD_BITS + b*8 +: 8] = cpu_wdata[b*8 +: 8];
        end
    end

    // State register
    cache_state_t state_q, state_d;
    logic         miss_start, fill_done, acc_write;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            victim_q <= '0;
        end else begin
            state_q <= state_d;
            if (miss_start) victim_q <= victim_way;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {req_tag, set_idx, {LOW_W{1'b0}}};
        mem_wdata  = data_q[set_idx][victim_q];
        miss_start = 1'b0;
        fill_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && hit) begin
                    cpu_ready = 1'b1;
                end else if (cpu_req) begin
                    miss_start = 1'b1;
                    state_d = (valid_q[set_idx][victim_way] && dirty_q[set_idx][victim_way])
                              ? ST_WRITEBACK : ST_REFILL;
                end
            end
            ST_WRITEBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {tag_q[set_idx][victim_q], set_idx, {LOW_W{1'b0}}};
                if (mem_ready) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    fill_done = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign acc_write = cpu_ready && cpu_we;

    // Tag and data arrays (no reset needed)
    always_ff @(posedge clk) begin
        if (acc_write) data_q[set_idx][hit_way] <= hit_line_new;
        if (fill_done) begin
            data_q[set_idx][victim_q] <= mem_rdata;
            tag_q[set_idx][victim_q]  <= req_tag;
        end
    end

    // Status bits: valid, modified, age
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                age_q[s]   <= '0;
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (tick && age_q[s][w] != '0) age_q[s][w] <= age_q[s][w] - 1'b1;
                end
            end
            if (cpu_ready) age_q[set_idx][hit_way] <= AGE_MAX;
            if (acc_write) dirty_q[set_idx][hit_way] <= 1'b1;
            if (fill_done) begin
                age_q[set_idx][victim_q]   <= AGE_MAX;
                valid_q[set_idx][victim_q] <= 1'b1;
                dirty_q[set_idx][victim_q] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int LOW_W = 2 + $clog2(LINE_WORDS);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_no_ready_in_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    assert_ready_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    assert_wb_before_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_we) |=> (mem_req && !mem_we));

    assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LOW_W-1:0] == '0));
endmodule

bind setassoc_cache cache_chk #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_cache_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr)
);

// File: tb/test_setassoc_cache.sv
`timescale 1ns/1ps
module test_setassoc_cache;
    localparam int ADDR_W = 32;
    localparam int LINE_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [3:0]        cpu_be = '0;
    logic [31:0]       cpu_wdata = '0;
    logic              cpu_ready;
    logic [31:0]       cpu_rdata;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [LINE_W-1:0] mem_wdata;
    logic [LINE_W-1:0] mem_rdata = '0;
    logic              mem_ready = 1'b0;

    always #2.5 clk = ~clk;

    setassoc_cache i_setassoc_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [ADDR_W-1:0] last_wr_addr = '0;
    logic [1:0]        op_hist = '0;   // bit0 newest op: 1 write, 0 read
    logic [LINE_W-1:0] bmem [64];
    logic [31:0]       gold [128];
    bit                done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int tag, input int set, input int word);
        mk = (32'(tag) << 5) | (32'(set) << 3) | (32'(word) << 2);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
        merge = old;
        for (int b = 0; b < 4; b++) if (be[b]) merge[b*8 +: 8] = nw[b*8 +: 8];
    endfunction

    // Memory responder
    initial begin
        int lat;
        logic [ADDR_W-1:0] a0;
        logic w0;
        forever begin
            @(negedge clk);
            mem_ready = 1'b0;
            if (rst_n && mem_req) begin
                a0  = mem_addr;
                w0  = mem_we;
                lat = int'($urandom_range(1, 3));
                repeat (lat - 1) @(negedge clk);
                chk(mem_req && mem_addr == a0 && mem_we == w0, "R12 request held",
                    {31'd0, mem_req, mem_addr}, {31'd1, 1'b1, a0});
                if (mem_we) begin
                    bmem[mem_addr[8:3]] = mem_wdata;
                    wr_cnt++;
                    last_wr_addr = mem_addr;
                end else begin
                    mem_rdata = bmem[mem_addr[8:3]];
                    rd_cnt++;
                end
                op_hist = {op_hist[0], mem_we};
                mem_ready = 1'b1;
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd, output int lat);
        int rd0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = be;
        lat = 0;
        rd0 = rd_cnt;
        while (1) begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
            lat++;
        end
        if (lat > 0) chk(rd_cnt > rd0, "R11 ready only after refill", 64'(rd_cnt), 64'(rd0 + 1));
        rd = cpu_rdata;
        if (we) gold[addr[8:2]] = merge(gold[addr[8:2]], wd, be);
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        int lat, r0, w0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 128; i++) begin
            gold[i] = 32'hC0DE0000 + 32'(i) * 32'h00010003;
            bmem[i >> 1][(i & 1) * 32 +: 32] = gold[i];
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ready && !mem_req, "R3 reset outputs idle", {cpu_ready, mem_req}, 64'd0);

        // R3 / R6: first access misses, one read, no write
        r0 = rd_cnt; w0 = wr_cnt;
        access(0, mk(1, 0, 0), 0, 0, rd, lat);
        chk(lat > 0, "R3 first access after reset misses", 64'(lat), 64'd1);
        chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R6 clean fill is one read",
            {32'(rd_cnt - r0), 32'(wr_cnt - w0)}, {32'd1, 32'd0});
        chk(rd == gold[mk(1, 0, 0) >> 2], "R4 load data", rd, gold[mk(1, 0, 0) >> 2]);
        // R2 / R1: same line, other word hits
        r0 = rd_cnt;
        access(0, mk(1, 0, 1), 0, 0, rd, lat);
        chk(lat == 0 && rd_cnt == r0, "R1 R2 other word of line hits", 64'(lat), 64'd0);
        chk(rd == gold[mk(1, 0, 1) >> 2], "R1 word select", rd, gold[mk(1, 0, 1) >> 2]);
        // R4: partial store hit
        access(1, mk(1, 0, 0), 32'h11223344, 4'b0101, rd, lat);
        chk(lat == 0, "R2 store hit same cycle", 64'(lat), 64'd0);
        access(0, mk(1, 0, 0), 0, 0, rd, lat);
        chk(rd == gold[mk(1, 0, 0) >> 2], "R4 byte enable merge", rd, gold[mk(1, 0, 0) >> 2]);

        // R7 fills way1, R9 then evicts way0 (dirty tag1) -> R5
        access(0, mk(2, 0, 0), 0, 0, rd, lat);
        r0 = rd_cnt; w0 = wr_cnt;
        access(0, mk(3, 0, 1), 0, 0, rd, lat);
        chk(wr_cnt == w0 + 1 && rd_cnt == r0 + 1, "R5 dirty victim write then read",
            {32'(wr_cnt - w0), 32'(rd_cnt - r0)}, {32'd1, 32'd1});
        chk(op_hist == 2'b10, "R5 write-back precedes refill", 64'(op_hist), 64'(2'b10));
        chk(last_wr_addr == mk(1, 0, 0), "R1 R5 write-back line address", last_wr_addr, mk(1, 0, 0));
        chk(bmem[mk(1, 0, 0) >> 3][31:0] == gold[mk(1, 0, 0) >> 2], "R5 written-back data",
            bmem[mk(1, 0, 0) >> 3][31:0], gold[mk(1, 0, 0) >> 2]);
        chk(rd == gold[mk(3, 0, 1) >> 2], "R4 refill data", rd, gold[mk(3, 0, 1) >> 2]);
        access(0, mk(2, 0, 0), 0, 0, rd, lat);
        chk(lat == 0, "R9 way1 kept when no age is zero", 64'(lat), 64'd0);
        access(0, mk(1, 0, 0), 0, 0, rd, lat);
        chk(lat > 0, "R9 way0 was the victim", 64'(lat), 64'd1);

        // R7: invalid way preferred over aged-out valid way (set 1)
        access(0, mk(1, 1, 0), 0, 0, rd, lat);
        repeat (200) @(posedge clk);
        access(0, mk(2, 1, 0), 0, 0, rd, lat);
        access(0, mk(1, 1, 0), 0, 0, rd, lat);
        chk(lat == 0, "R7 invalid way filled first", 64'(lat), 64'd0);

        // R8 / R10: after decay only tag1 refreshed; tag2 (age 0) is replaced
        repeat (200) @(posedge clk);
        access(0, mk(1, 1, 1), 0, 0, rd, lat);
        access(0, mk(3, 1, 0), 0, 0, rd, lat);
        access(0, mk(1, 1, 0), 0, 0, rd, lat);
        chk(lat == 0, "R10 refreshed line survives", 64'(lat), 64'd0);
        access(0, mk(2, 1, 0), 0, 0, rd, lat);
        chk(lat > 0, "R8 zero-age way replaced", 64'(lat), 64'd1);

        // R11: store miss allocates then writes
        r0 = rd_cnt;
        access(1, mk(5, 2, 1), 32'hDEADBEEF, 4'b1111, rd, lat);
        chk(lat > 0 && rd_cnt == r0 + 1, "R11 store miss allocates", 64'(lat), 64'd1);
        access(0, mk(5, 2, 1), 0, 0, rd, lat);
        chk(lat == 0 && rd == 32'hDEADBEEF, "R11 store applied after fill", rd, 64'hDEADBEEF);

        // Random mix against the bench memory image
        for (int n = 0; n < 400; n++) begin
            bit we;
            logic [31:0] a, wd;
            logic [3:0] be;
            we = 1'($urandom_range(0, 1));
            a  = mk(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), int'($urandom_range(0, 1)));
            wd = $urandom;
            be = 4'($urandom_range(1, 15));
            access(we, a, wd, be, rd, lat);
            if (!we) chk(rd == gold[a[8:2]], "R4 random load", rd, gold[a[8:2]]);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule